// File: doc/BRIEF.md
# Programmable display timing engine

This block generates the raster timing for a display output from a pixel clock. One counter runs over the whole frame in pixel clocks. A second counter tracks the horizontal position inside the current line. Every vertical limit (sync width, display window, active window) is an absolute pixel-clock offset from the start of the frame, not a line number. Software can therefore fold a horizontal skew straight into those offsets. The block drives horizontal and vertical sync, data enable, a display-window flag, an active-window flag and a one-cycle fetch-start pulse. It also chooses the output pixel from the incoming pixel, a border colour or an underflow colour.

Configuration goes through a plain write-enable, address and data bus, and reads come back combinationally. Timing registers are held in a shadow copy and only take effect at a frame boundary, so a frame in progress is never disturbed. Frame and line counters can be read back. They read zero while the engine is off and restart from zero when it is switched on.

Top module: `vid_timer`

## Requirements
- R1: With the engine enabled (word 0x00 bit 0), the frame pixel counter runs from 0 to the frame length (word 0x0C) minus 1 and wraps. The line position runs from 0 to the line period minus 1, and also returns to 0 at a frame wrap. While disabled, both are held at 0.
- R2: Raw hsync is high while the line position is below the pulse width. The line word at 0x08 holds the period in bits 31:16 and the pulse width in bits 15:0. Raw vsync is high while the frame counter is below the vsync width in pixel clocks (word 0x10).
- R3: Data enable and the display-window flag are high when the frame counter lies within [0x14, 0x18] inclusive and the line position lies within the display x range. Word 0x1C holds the end x in bits 31:16 and the start x in bits 15:0.
- R4: The active-window flag equals the display window narrowed by two limits. When config word 0x04 bit 29 is set, the line position must lie in the x range of word 0x20 (end in bits 31:16, start in bits 15:0). When bit 30 is set, the frame counter must lie within [0x24, 0x28].
- R5: The output pixel is 0 outside the display window. Inside the display window but outside the active window it is the border colour (0x2C). Inside the active window it is the input pixel when pixel-valid is high, and the underflow colour (0x30) otherwise.
- R6: Polarity word 0x34 inverts hsync with bit 0, vsync with bit 1 and data enable with bit 2.
- R7: When config bit 31 is set, the fetch output pulses for one cycle when the frame counter equals word 0x3C.
- R8: Word 0x38 bit 0 enables the frame counter and bit 1 enables the line counter. The frame count (read at 0x40) increments at each frame wrap. The line count (read at 0x44) increments at each line end. Both read zero while the engine is disabled and are cleared by disabling it.
- R9: Writes to words 0x04 to 0x34 and 0x3C take effect only at the frame boundary, which is the cycle where the frame counter equals the frame length minus 1, or at any time while the engine is disabled. A write that lands in the boundary cycle applies to the new frame. The enable and counter-enable words act at once.
- R10: All sync, window, fetch and pixel outputs are registered. They appear one clock after the counter state and input pixel they reflect.
- R11: A written configuration word reads back its new value in the next cycle, whatever the frame boundary state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| pix_valid | input | 1 | Input pixel is valid this cycle |
| pix_in | input | COLW | Input pixel |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| den_o | output | 1 | Data enable after polarity |
| disp_win_o | output | 1 | Inside display window |
| act_win_o | output | 1 | Inside active window |
| fetch_o | output | 1 | Fetch-start pulse |
| pix_o | output | COLW | Output pixel |

## Verification
Two events can fall in the same cycle: a register write, and the frame boundary at which shadow values are transferred. The bench waits until the frame counter sits on its last count and issues a line-word write exactly then. It judges the case by counting the hsync width of the next line, which must already use the new value. A write issued mid-frame must leave the remaining lines unchanged. Line-count and frame-count increments also coincide at every frame wrap, and register readback is compared against a reference model that tracks both counts.

// File: rtl/vid_timer.sv
module vid_timer #(
  parameter int COLW = 24,
  parameter int NREG = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_we,
  input  logic [7:0]      reg_addr,
  input  logic [31:0]     reg_wdata,
  output logic [31:0]     reg_rdata,
  input  logic            pix_valid,
  input  logic [COLW-1:0] pix_in,
  output logic            hsync_o,
  output logic            vsync_o,
  output logic            den_o,
  output logic            disp_win_o,
  output logic            act_win_o,
  output logic            fetch_o,
  output logic [COLW-1:0] pix_o
);
  localparam int IW = $clog2(NREG);

  // word map: 0 enable, 1 config, 2 line, 3 frame length, 4 vsync width,
  // 5/6 display v, 7 display x, 8 active x, 9/10 active v, 11 border,
  // 12 underflow, 13 polarity, 14 counter enables, 15 fetch start
  logic [31:0] shd [NREG];
  logic [31:0] shd_nxt [NREG];
  logic [31:0] cur [NREG];
  logic [31:0] fcnt, frm_cnt, line_cnt;
  logic [15:0] hcnt;

  wire [IW-1:0] widx   = reg_addr[IW+1:2];
  wire          whit   = reg_we && reg_addr[7:IW+2] == '0 && reg_addr[1:0] == 2'b00;
  wire          en     = shd[0][0];
  wire [1:0]    cnt_en = shd[14][1:0];

  wire [15:0] hper   = cur[2][31:16];
  wire [15:0] hpw    = cur[2][15:0];
  wire [31:0] flen   = cur[3];
  wire        wrap_f = en && ({1'b0, fcnt} + 33'd1 >= {1'b0, flen});
  wire        wrap_l = en && ({1'b0, hcnt} + 17'd1 >= {1'b0, hper});
  wire        load   = !en || wrap_f;

  always_comb
    for (int i = 0; i < NREG; i++)
      shd_nxt[i] = (whit && widx == IW'(i)) ? reg_wdata : shd[i];

  wire dv   = fcnt >= cur[5] && fcnt <= cur[6];
  wire dh   = hcnt >= cur[7][15:0] && hcnt <= cur[7][31:16];
  wire disp = en && dv && dh;
  wire ah   = !cur[1][29] || (hcnt >= cur[8][15:0] && hcnt <= cur[8][31:16]);
  wire av   = !cur[1][30] || (fcnt >= cur[9] && fcnt <= cur[10]);
  wire actw = disp && ah && av;
  wire hs   = en && hcnt < hpw;
  wire vs   = en && fcnt < cur[4];
  wire fet  = en && cur[1][31] && fcnt == cur[15];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        shd[i] <= '0;
        cur[i] <= '0;
      end
      fcnt <= '0; hcnt <= '0; frm_cnt <= '0; line_cnt <= '0;
      hsync_o <= 1'b0; vsync_o <= 1'b0; den_o <= 1'b0;
      disp_win_o <= 1'b0; act_win_o <= 1'b0; fetch_o <= 1'b0;
      pix_o <= '0;
    end else begin
      for (int i = 0; i < NREG; i++) begin
        shd[i] <= shd_nxt[i];
        if (load) cur[i] <= shd_nxt[i];
      end
      if (!en) begin
        fcnt <= '0; hcnt <= '0; frm_cnt <= '0; line_cnt <= '0;
      end else begin
        fcnt <= wrap_f ? '0 : fcnt + 32'd1;
        hcnt <= (wrap_f || wrap_l) ? '0 : hcnt + 16'd1;
        if (cnt_en[0] && wrap_f) frm_cnt <= frm_cnt + 32'd1;
        if (cnt_en[1] && (wrap_f || wrap_l)) line_cnt <= line_cnt + 32'd1;
      end
      hsync_o    <= hs ^ cur[13][0];
      vsync_o    <= vs ^ cur[13][1];
      den_o      <= disp ^ cur[13][2];
      disp_win_o <= disp;
      act_win_o  <= actw;
      fetch_o    <= fet;
      pix_o      <= !disp ? '0 : !actw ? cur[11][COLW-1:0] :
                    pix_valid ? pix_in : cur[12][COLW-1:0];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr[7:IW+2] == '0) reg_rdata = shd[widx];
    else if (reg_addr == 8'h40) reg_rdata = en ? frm_cnt : '0;
    else if (reg_addr == 8'h44) reg_rdata = en ? line_cnt : '0;
  end

  assert_fcnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (en && flen != 0) |-> fcnt < flen);
  assert_act_in_disp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    act_win_o |-> disp_win_o);
  assert_pix_blank_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !disp_win_o |-> pix_o == '0);
  assert_off_counts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (frm_cnt == '0 && line_cnt == '0));
  assert_hold_midframe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap_f) |=> ($stable(cur[2]) && $stable(cur[3]) && $stable(cur[13])));
endmodule

// File: tb/test_vid_timer.sv
module test_vid_timer;
  localparam int CLK_PERIOD = 10;
  localparam int COLW = 24;

  logic clk = 0, rst_n = 0, reg_we = 0, pix_valid = 0;
  logic [7:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [COLW-1:0] pix_in = 0, pix_o;
  logic hsync_o, vsync_o, den_o, disp_win_o, act_win_o, fetch_o;

  int n_chk = 0, n_fail = 0;
  bit chk_on = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vid_timer #(.COLW(COLW)) i_vid_timer (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
    .pix_in(pix_in), .hsync_o(hsync_o), .vsync_o(vsync_o), .den_o(den_o),
    .disp_win_o(disp_win_o), .act_win_o(act_win_o), .fetch_o(fetch_o),
    .pix_o(pix_o));

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // reference model, built from the requirements
  logic [31:0] m_shd [16], m_cur [16], nx [16];
  longint m_f, m_x;
  logic [31:0] m_frm, m_line;
  logic e_hs, e_vs, e_den, e_disp, e_act, e_fet;
  logic [COLW-1:0] e_pix;

  function automatic bit inr(longint v, longint lo, longint hi);
    return v >= lo && v <= hi;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) begin m_shd[i] = 0; m_cur[i] = 0; end
      m_f = 0; m_x = 0; m_frm = 0; m_line = 0;
      {e_hs, e_vs, e_den, e_disp, e_act, e_fet} = '0; e_pix = 0;
    end else begin
      bit en, disp, act, wf, wl;
      en = m_shd[0][0];
      for (int i = 0; i < 16; i++) nx[i] = m_shd[i];
      if (reg_we && reg_addr < 8'h40 && reg_addr[1:0] == 0) nx[reg_addr[5:2]] = reg_wdata;
      disp = en && inr(m_f, m_cur[5], m_cur[6]) && inr(m_x, m_cur[7][15:0], m_cur[7][31:16]);
      act  = disp && (!m_cur[1][29] || inr(m_x, m_cur[8][15:0], m_cur[8][31:16]))
                  && (!m_cur[1][30] || inr(m_f, m_cur[9], m_cur[10]));
      e_hs = (en && m_x < m_cur[2][15:0]) ^ m_cur[13][0];
      e_vs = (en && m_f < m_cur[4]) ^ m_cur[13][1];
      e_den = disp ^ m_cur[13][2];
      e_disp = disp; e_act = act;
      e_fet = en && m_cur[1][31] && m_f == m_cur[15];
      e_pix = !disp ? '0 : !act ? m_cur[11][COLW-1:0] : pix_valid ? pix_in : m_cur[12][COLW-1:0];
      wf = en && (m_f + 1 >= m_cur[3]);
      wl = en && (m_x + 1 >= m_cur[2][31:16]);
      if (!en) begin m_f = 0; m_x = 0; m_frm = 0; m_line = 0; end
      else begin
        if (m_shd[14][0] && wf) m_frm++;
        if (m_shd[14][1] && (wf || wl)) m_line++;
        m_f = wf ? 0 : m_f + 1;
        m_x = (wf || wl) ? 0 : m_x + 1;
      end
      if (!en || wf) for (int i = 0; i < 16; i++) m_cur[i] = nx[i];
      for (int i = 0; i < 16; i++) m_shd[i] = nx[i];
    end
  end

  always @(negedge clk) if (chk_on) begin
    check("R2 R6 R10 hsync", 32'(hsync_o), 32'(e_hs));
    check("R2 R6 vsync", 32'(vsync_o), 32'(e_vs));
    check("R3 R6 den", 32'(den_o), 32'(e_den));
    check("R3 R1 disp_win", 32'(disp_win_o), 32'(e_disp));
    check("R4 act_win", 32'(act_win_o), 32'(e_act));
    check("R7 fetch", 32'(fetch_o), 32'(e_fet));
    check("R5 pixel", 32'(pix_o), 32'(e_pix));
  end

  always @(negedge clk) if (rst_n) begin
    pix_in <= COLW'($urandom);
    pix_valid <= ($urandom % 4) != 0;
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic setup(int hpw, int hbp, int w, int hfp, int vpw, int vbp, int h, int vfp,
                       int skew, int ahs, int ahe, int al0, int al1, logic [2:0] cfg_hi);
    int hper, vtot, dvs;
    hper = hpw + hbp + w + hfp;
    vtot = vpw + vbp + h + vfp;
    dvs = (vpw + vbp) * hper + skew;
    wr(8'h08, {16'(hper), 16'(hpw)});
    wr(8'h0C, vtot * hper);
    wr(8'h10, vpw * hper);
    wr(8'h14, dvs);
    wr(8'h18, (vtot - vfp) * hper + skew - 1);
    wr(8'h1C, {16'(hper - hfp - 1), 16'(hbp + hpw)});
    wr(8'h20, {16'(ahe), 16'(ahs)});
    wr(8'h24, dvs + al0 * hper);
    wr(8'h28, dvs + al1 * hper - 1);
    wr(8'h2C, 32'h00AA55);
    wr(8'h30, 32'h00F00F);
    wr(8'h38, 32'h3);
    wr(8'h3C, 32'd2);
    wr(8'h04, {cfg_hi, 29'd0});
  endtask

  logic [31:0] rv;
  int cnt;

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R10 reset pix", 32'(pix_o), 0);
    check("R10 reset syncs", {29'd0, hsync_o, vsync_o, den_o}, 0);
    rd(8'h40, rv); check("R8 reset frame count", rv, 0);
    chk_on = 1;

    setup(2, 3, 8, 2, 1, 2, 4, 1, 1, 6, 10, 1, 3, 3'b111);
    rd(8'h08, rv); check("R11 line word readback", rv, {16'd15, 16'd2});
    rd(8'h0C, rv); check("R11 frame length readback", rv, 32'd120);
    rd(8'h1C, rv); check("R11 display x readback", rv, {16'd12, 16'd5});
    wr(8'h00, 1);
    repeat (260) @(negedge clk);
    rd(8'h40, rv); check("R8 frame count", rv, m_frm);
    rd(8'h44, rv); check("R8 line count", rv, m_line);

    // one fetch pulse per frame
    cnt = 0;
    repeat (120) begin @(negedge clk); if (fetch_o) cnt++; end
    check("R7 one fetch per frame", cnt, 1);

    // mid-frame write must not touch the current frame
    do @(negedge clk); while (m_f != 20);
    wr(8'h08, {16'd15, 16'd4});
    rd(8'h08, rv); check("R11 readback before boundary", rv, {16'd15, 16'd4});
    while (m_x != 14) @(negedge clk);
    cnt = 0;
    repeat (15) begin @(negedge clk); if (hsync_o) cnt++; end
    check("R9 old width kept mid-frame", cnt, 2);

    // write landing exactly on the boundary cycle applies to the new frame
    do @(negedge clk); while (m_f != 118);
    @(negedge clk);
    reg_we = 1; reg_addr = 8'h08; reg_wdata = {16'd15, 16'd3};
    @(negedge clk); reg_we = 0;
    cnt = 0;
    repeat (15) begin @(negedge clk); if (hsync_o) cnt++; end
    check("R9 boundary write applies to new frame", cnt, 3);

    // polarity inversion
    wr(8'h34, 32'h7);
    repeat (260) @(negedge clk);

    // random configurations, written while running
    for (int k = 0; k < 8; k++) begin
      int w, hbp, hpw, hfp, h;
      hpw = 1 + $urandom % 3; hbp = 1 + $urandom % 3; w = 4 + $urandom % 5;
      hfp = 1 + $urandom % 3; h = 2 + $urandom % 3;
      setup(hpw, hbp, w, hfp, 1 + $urandom % 2, 1 + $urandom % 2, h, 1 + $urandom % 2,
            $urandom % 3, hpw + hbp + 1, hpw + hbp + w - 2, 0, 1 + $urandom % h,
            3'($urandom));
      wr(8'h34, $urandom % 8);
      repeat (150 + $urandom % 200) @(negedge clk);
      rd(8'h44, rv); check("R8 line count random", rv, m_line);
    end

    // disable clears counters, re-enable restarts
    wr(8'h00, 0);
    rd(8'h40, rv); check("R8 disabled frame count", rv, 0);
    rd(8'h44, rv); check("R8 disabled line count", rv, 0);
    check("R1 disabled no window", 32'(disp_win_o), 0);
    wr(8'h00, 1);
    repeat (5) @(negedge clk);
    rd(8'h40, rv); check("R8 restart frame count", rv, 0);
    repeat (100) @(negedge clk);
    chk_on = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule